// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

When a two-input floating-point operation has at least one NaN operand, this block decides which NaN the result carries. The operand words arrive together with a class code for each operand, which the operand decoder upstream has already computed. The block applies one of four propagation policies, chosen at run time. It returns the chosen operand unchanged, or made quiet if the operand was signaling. In default-NaN mode it returns the canonical default NaN instead. It also raises an invalid flag whenever either operand is a signaling NaN.

The arithmetic result itself is computed elsewhere. The caller uses the output of this block only when at least one operand is a NaN. All outputs are registered, so every output reflects the inputs sampled at the previous rising clock edge. The operand layout is sign, then exponent, then fraction, with the fraction `FRAC_W` bits wide. The quiet-marker bit is the top fraction bit. Its meaning is set by a polarity input.

Top module: `nanp_sel`

## Requirements
- R1: Reset is synchronous and active-low. While reset is held, `res`, `pick_b` and `invalid` are all zero. After reset, each output reflects the inputs sampled at the previous rising edge.
- R2: Class codes are 2'b00 number, 2'b01 quiet NaN, 2'b10 signaling NaN and 2'b11 treated as a number. Under policy 0 (signaling-first), the block takes a if a is signaling, else b if b is signaling, else a if a is quiet, else b.
- R3: Under policy 1 (first-NaN), the block takes a when a is a NaN of either kind, otherwise b.
- R4: Under policy 2 (switchable), with `use_first` = 1 the block takes a if a is a NaN, else b. With `use_first` = 0 it takes b if b is a NaN, else a.
- R5: Under policy 3 (magnitude), a quiet NaN beats a signaling NaN, and a NaN beats a non-NaN. When neither operand is a NaN, b is taken.
- R6: Under policy 3, when both operands are NaNs of the same kind, the one with the larger unsigned fraction field wins. On equal fractions, a wins when its sign-and-exponent field is numerically smaller than b's, so a positive operand beats a negative one. Otherwise b wins.
- R7: `invalid` is 1 exactly when either class is signaling. This holds in every mode, including default-NaN mode.
- R8: A chosen signaling operand is made quiet. With `quiet_inv` = 0 the block sets fraction bit FRAC_W-1. With `quiet_inv` = 1 it clears bit FRAC_W-1 and sets bit FRAC_W-2. No other bit changes.
- R9: With `dflt_mode` = 1, `res` is the default NaN whatever the policy: sign 0 and exponent all ones. Its fraction is only bit FRAC_W-1 set when `quiet_inv` = 0, and all fraction bits except bit FRAC_W-1 set when `quiet_inv` = 1. `pick_b` still reports the policy decision.
- R10: A chosen operand that is not signaling is passed to `res` bit for bit when `dflt_mode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | W | First operand word |
| op_b | input | W | Second operand word |
| cls_a | input | 2 | Class code of op_a |
| cls_b | input | 2 | Class code of op_b |
| policy | input | 2 | Propagation policy: 0 signaling-first, 1 first-NaN, 2 switchable, 3 magnitude |
| use_first | input | 1 | Direction control for the switchable policy |
| dflt_mode | input | 1 | Force the default NaN on the result |
| quiet_inv | input | 1 | Quiet-bit polarity: 0 means a set top fraction bit marks quiet |
| res | output | W | Registered NaN result |
| pick_b | output | 1 | Registered selection: 1 when op_b was chosen |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
The embedded properties check the following on every cycle. The invalid flag matches the classes from the previous cycle. A chosen signaling operand always leaves with its quiet marker in the polarity asked for. A non-signaling choice passes through bit for bit. Default-NaN mode yields the fixed pattern. The signaling-first and first-NaN priorities for operand a also hold. The properties cannot show whether the magnitude policy, its sign tie-break and the switchable direction pick the right operand across all class pairs. The bench's full sweep covers this: every class pair, policy, mode bit, polarity, and fraction ordering, including equal fractions with opposite signs.

// File: rtl/nanp_pkg.sv
// Shared class and policy encodings for the NaN result selector.
// Assumes the class codes are produced by an upstream operand decoder.
package nanp_pkg;

    typedef enum logic [1:0] {
        CLS_NUM   = 2'b00,
        CLS_QUIET = 2'b01,
        CLS_SIG   = 2'b10,
        CLS_RSVD  = 2'b11
    } nan_cls_e;

    typedef enum logic [1:0] {
        POL_SIGFIRST = 2'd0,
        POL_FIRST    = 2'd1,
        POL_SWITCH   = 2'd2,
        POL_MAG      = 2'd3
    } nan_pol_e;

    function automatic logic cls_is_nan(input logic [1:0] c);
        return (c == CLS_QUIET) || (c == CLS_SIG);
    endfunction

    function automatic logic cls_is_sig(input logic [1:0] c);
        return c == CLS_SIG;
    endfunction

    function automatic logic cls_is_quiet(input logic [1:0] c);
        return c == CLS_QUIET;
    endfunction

endpackage

// File: rtl/nanp_rank.sv
// Magnitude ranking of two operand words for the magnitude policy.
// Reports whether operand a ranks above b: larger unsigned fraction first,
// then on a tie the numerically smaller sign-and-exponent field.
// Assumes FRAC_W < W.
module nanp_rank #(
    parameter int W      = 16,
    parameter int FRAC_W = 10
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         a_above
);
    localparam int HI_W = W - FRAC_W;

    logic [FRAC_W-1:0] frac_a, frac_b;
    logic [HI_W-1:0]   hi_a, hi_b;

    // Split the words and compare fraction first, upper field second.
    always_comb begin
        frac_a = op_a[FRAC_W-1:0];
        frac_b = op_b[FRAC_W-1:0];
        hi_a   = op_a[W-1:FRAC_W];
        hi_b   = op_b[W-1:FRAC_W];
        if (frac_a != frac_b) a_above = frac_a > frac_b;
        else                  a_above = hi_a < hi_b;
    end
endmodule

// File: rtl/nanp_pick.sv
// Policy decision: picks operand b (1) or a (0) from the two class codes,
// the policy select, the use-first control and the magnitude ranking.
// Assumes classes come from nanp_pkg encodings; 2'b11 counts as a number.
module nanp_pick
    import nanp_pkg::*;
(
    input  logic [1:0] cls_a,
    input  logic [1:0] cls_b,
    input  logic [1:0] policy,
    input  logic       use_first,
    input  logic       a_above,
    output logic       take_b
);
    logic na, nb, sa, sb, qa, qb;

    // Decode class flags once for all policies.
    always_comb begin
        na = cls_is_nan(cls_a);
        nb = cls_is_nan(cls_b);
        sa = cls_is_sig(cls_a);
        sb = cls_is_sig(cls_b);
        qa = cls_is_quiet(cls_a);
        qb = cls_is_quiet(cls_b);
    end

    // Apply the selected priority scheme.
    always_comb begin
        take_b = 1'b1;
        unique case (nan_pol_e'(policy))
            POL_SIGFIRST: begin
                if (sa)      take_b = 1'b0;
                else if (sb) take_b = 1'b1;
                else if (qa) take_b = 1'b0;
                else         take_b = 1'b1;
            end
            POL_FIRST:  take_b = !na;
            POL_SWITCH: take_b = use_first ? !na : nb;
            POL_MAG: begin
                if (sa)      take_b = sb ? !a_above : qb;
                else if (qa) take_b = qb ? !a_above : 1'b0;
                else         take_b = 1'b1;
            end
            default: take_b = 1'b1;
        endcase
    end
endmodule

// File: rtl/nanp_shape.sv
// Output shaping: quiets a chosen signaling operand in the configured
// polarity, or substitutes the default NaN when default mode is on.
// Assumes FRAC_W >= 2 so the secondary quiet bit exists.
module nanp_shape #(
    parameter int W      = 16,
    parameter int FRAC_W = 10
) (
    input  logic [W-1:0] chosen,
    input  logic         chosen_sig,
    input  logic         dflt_mode,
    input  logic         quiet_inv,
    output logic [W-1:0] shaped
);
    localparam int QB = FRAC_W - 1;

    logic [W-1:0] quieted;
    logic [W-1:0] dflt_nan;

    // Force the quiet marker according to polarity.
    always_comb begin
        quieted = chosen;
        if (quiet_inv) begin
            quieted[QB]   = 1'b0;
            quieted[QB-1] = 1'b1;
        end else begin
            quieted[QB]   = 1'b1;
        end
    end

    // Build the default NaN: positive, all-ones exponent, polarity fraction.
    always_comb begin
        dflt_nan                 = '0;
        dflt_nan[W-2:FRAC_W]     = '1;
        dflt_nan[FRAC_W-1:0]     = quiet_inv ? {1'b0, {(FRAC_W-1){1'b1}}}
                                             : {1'b1, {(FRAC_W-1){1'b0}}};
    end

    // Final output mux.
    always_comb begin
        if (dflt_mode)       shaped = dflt_nan;
        else if (chosen_sig) shaped = quieted;
        else                 shaped = chosen;
    end
endmodule

// File: rtl/nanp_sel.sv
// Two-operand NaN result selector, top level. Combines ranking, policy
// pick and output shaping, then registers result, selection and invalid.
// Assumes cls_a/cls_b are valid for op_a/op_b in the same cycle.
module nanp_sel
    import nanp_pkg::*;
#(
    parameter int W      = 16,
    parameter int FRAC_W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   cls_a,
    input  logic [1:0]   cls_b,
    input  logic [1:0]   policy,
    input  logic         use_first,
    input  logic         dflt_mode,
    input  logic         quiet_inv,
    output logic [W-1:0] res,
    output logic         pick_b,
    output logic         invalid
);
    localparam int QB = FRAC_W - 1;

    logic         a_above;
    logic         take_b;
    logic [W-1:0] chosen;
    logic         chosen_sig;
    logic [W-1:0] shaped;
    logic         any_sig;

    nanp_rank #(.W(W), .FRAC_W(FRAC_W)) u_rank (
        .op_a(op_a), .op_b(op_b), .a_above(a_above)
    );

    nanp_pick u_pick (
        .cls_a(cls_a), .cls_b(cls_b), .policy(policy),
        .use_first(use_first), .a_above(a_above), .take_b(take_b)
    );

    // Route the chosen operand and its signaling status.
    always_comb begin
        chosen     = take_b ? op_b : op_a;
        chosen_sig = take_b ? cls_is_sig(cls_b) : cls_is_sig(cls_a);
        any_sig    = cls_is_sig(cls_a) || cls_is_sig(cls_b);
    end

    nanp_shape #(.W(W), .FRAC_W(FRAC_W)) u_shape (
        .chosen(chosen), .chosen_sig(chosen_sig), .dflt_mode(dflt_mode),
        .quiet_inv(quiet_inv), .shaped(shaped)
    );

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res     <= '0;
            pick_b  <= 1'b0;
            invalid <= 1'b0;
        end else begin
            res     <= shaped;
            pick_b  <= take_b;
            invalid <= any_sig;
        end
    end

    // Marks that the output register holds a post-reset sample.
    logic primed;
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (res == '0 && !pick_b && !invalid));

    assert_invalid_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> invalid == ($past(cls_a) == 2'b10 || $past(cls_b) == 2'b10));

    assert_quiet_marker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(dflt_mode) &&
         ((pick_b && $past(cls_b) == 2'b10) || (!pick_b && $past(cls_a) == 2'b10)))
        |-> (res[QB] == !$past(quiet_inv)));

    assert_default_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(dflt_mode)) |->
        (res[W-1] == 1'b0 && &res[W-2:FRAC_W] &&
         res[QB] == !$past(quiet_inv) && res[QB-1:0] == {QB{$past(quiet_inv)}}));

    assert_pass_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(dflt_mode) &&
         !(pick_b ? $past(cls_b) == 2'b10 : $past(cls_a) == 2'b10))
        |-> res == (pick_b ? $past(op_b) : $past(op_a)));

    assert_sigfirst_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(policy) == 2'd0 && $past(cls_a) == 2'b10) |-> !pick_b);

    assert_firstnan_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(policy) == 2'd1 &&
         ($past(cls_a) == 2'b01 || $past(cls_a) == 2'b10)) |-> !pick_b);
endmodule

// File: tb/test_nanp_sel.sv
`timescale 1ns/1ps
module test_nanp_sel;
    localparam int W  = 16;
    localparam int FW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic [1:0]    cls_a = '0, cls_b = '0, policy = '0;
    logic          use_first = 1'b0, dflt_mode = 1'b0, quiet_inv = 1'b0;
    logic [W-1:0]  res;
    logic          pick_b, invalid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    nanp_sel #(.W(W), .FRAC_W(FW)) i_nanp_sel (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .cls_a(cls_a), .cls_b(cls_b), .policy(policy), .use_first(use_first),
        .dflt_mode(dflt_mode), .quiet_inv(quiet_inv),
        .res(res), .pick_b(pick_b), .invalid(invalid)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s got=%h exp=%h (pol=%0d ca=%0d cb=%0d uf=%0b dn=%0b qi=%0b)",
                     req, got, want, policy, cls_a, cls_b, use_first, dflt_mode, quiet_inv);
        end
    endtask

    // Build an operand from class, sign and 9-bit payload.
    function automatic logic [W-1:0] mk(input int c, input bit s, input logic [8:0] p, input bit qi);
        logic [W-1:0] v;
        bit isn = (c == 1) || (c == 2);
        bit msb;
        if (!isn) return {s, 5'h0A, 1'b0, p};
        msb = (c == 1) ? !qi : qi;
        v = {s, 5'h1F, msb, p};
        return v;
    endfunction

    function automatic bit want_b(input int pol, input bit uf, input int ca, input int cb, input bit a_big);
        bit an = (ca == 1) || (ca == 2), bn = (cb == 1) || (cb == 2);
        case (pol)
            0: return (ca == 2) ? 0 : (cb == 2) ? 1 : (ca == 1) ? 0 : 1;
            1: return !an;
            2: return uf ? !an : bn;
            default: begin
                if (ca == 2) return (cb == 2) ? !a_big : (cb == 1);
                if (ca == 1) return (cb == 1) ? !a_big : 0;
                return 1;
            end
        endcase
    endfunction

    initial begin
        logic [8:0] pa_t [4] = '{9'h055, 9'h012, 9'h033, 9'h033};
        logic [8:0] pb_t [4] = '{9'h012, 9'h055, 9'h033, 9'h033};
        bit         sa_t [4] = '{0, 1, 0, 1};
        bit         sb_t [4] = '{0, 0, 1, 0};
        // Reset state with stimulus that would otherwise raise outputs (R1).
        op_a = 16'h7D55; op_b = 16'h7E11; cls_a = 2'b10; cls_b = 2'b10;
        repeat (3) @(negedge clk);
        check("R1 res", res, '0);
        check("R1 pick_b", {15'b0, pick_b}, '0);
        check("R1 invalid", {15'b0, invalid}, '0);
        rst_n = 1'b1;
        for (int qi = 0; qi < 2; qi++)
        for (int dn = 0; dn < 2; dn++)
        for (int pol = 0; pol < 4; pol++)
        for (int uf = 0; uf < 2; uf++)
        for (int ca = 0; ca < 4; ca++)
        for (int cb = 0; cb < 4; cb++)
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] a, b, ch, ew;
            bit a_big, eb, csig;
            a = mk(ca, sa_t[k], pa_t[k], qi[0]);
            b = mk(cb, sb_t[k], pb_t[k], qi[0]);
            op_a = a; op_b = b; cls_a = 2'(ca); cls_b = 2'(cb);
            policy = 2'(pol); use_first = uf[0]; dflt_mode = dn[0]; quiet_inv = qi[0];
            a_big = (a[9:0] > b[9:0]) || (a[9:0] == b[9:0] && a[15:10] < b[15:10]);
            eb = want_b(pol, uf[0], ca, cb, a_big);
            ch = eb ? b : a;
            csig = eb ? (cb == 2) : (ca == 2);
            if (dn != 0)   ew = qi ? 16'h7DFF : 16'h7E00;         // R9
            else if (csig) ew = qi ? ((ch & ~16'h0200) | 16'h0100)
                                   : (ch | 16'h0200);             // R8
            else           ew = ch;                               // R10
            @(posedge clk);
            @(negedge clk);
            case (pol)
                0: check("R2 pick", {15'b0, pick_b}, {15'b0, eb});
                1: check("R3 pick", {15'b0, pick_b}, {15'b0, eb});
                2: check("R4 pick", {15'b0, pick_b}, {15'b0, eb});
                default: check((a[9:0] == b[9:0]) ? "R6 pick" : "R5 pick",
                               {15'b0, pick_b}, {15'b0, eb});
            endcase
            check("R7 invalid", {15'b0, invalid}, {15'b0, ca == 2 || cb == 2});
            check(dn != 0 ? "R9 res" : (csig ? "R8 res" : "R10 res"), res, ew);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 got=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule